// File: doc/BRIEF.md
# SMBus Serial EEPROM Device

This block is the storage side of a small serial EEPROM that sits behind an SMBus slave protocol engine. The engine decodes the bus traffic and hands each transaction piece to this block as a one-cycle strobe, sharing a common byte lane. The block holds a 256-byte array, cleared by reset, and a current-position pointer.

Writes with a command treat the command byte as the starting array address. Every byte that follows is stored as data, with no length byte stripped, and the address wraps from the top of the array back to 0. Reads return the byte at the current position and step it forward. The first byte of a read with a command reloads the position from the command byte first. A send-byte sets the position. A quick command changes nothing.

Each instance answers one 7-bit bus address, set by a parameter, so a row of instances can cover consecutive addresses such as 0x50 to 0x57.

Top module: `smb_eeprom`

## Requirements
- R1: After reset every array byte reads 0x00, the current position is 0 and `rd_valid_o` is low.
- R2: Strobes act only while `sel_addr_i` equals the parameter `BUS_ADDR`. Otherwise they change neither the array nor the position, and give no read response.
- R3: `wcmd_i` loads the write address from `byte_i`. Each following `wdat_i` stores `byte_i` at the write address and then advances it by one. The first data byte lands at the command address.
- R4: A write that passes address 255 continues at address 0.
- R5: `rdat_i` with `rdat_first_i` high returns the byte at address `byte_i` and leaves the position at `byte_i`+1.
- R6: `recv_i`, and `rdat_i` with `rdat_first_i` low, return the byte at the current position and then advance the position by one modulo 256.
- R7: `send_i` loads the current position from `byte_i`.
- R8: `quick_i` has no effect on the array or the position.
- R9: Write-command and write-data strobes leave the current position unchanged.
- R10: `rd_valid_o` is high for exactly the cycle after each accepted read strobe, with `rd_data_o` valid in that cycle, and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_addr_i | input | 7 | 7-bit bus address of the current transaction |
| quick_i | input | 1 | Quick-command strobe |
| send_i | input | 1 | Send-byte strobe, the byte is on `byte_i` |
| recv_i | input | 1 | Receive-byte strobe |
| wcmd_i | input | 1 | Write command byte strobe, the byte is on `byte_i` |
| wdat_i | input | 1 | Write data byte strobe, the byte is on `byte_i` |
| rdat_i | input | 1 | Read-data strobe |
| rdat_first_i | input | 1 | Marks the first read of a read with a command, the command is on `byte_i` |
| byte_i | input | 8 | Shared byte lane |
| rd_data_o | output | 8 | Read response byte |
| rd_valid_o | output | 1 | Read response valid |

## Verification
On every cycle, the assertions check how each decoded operation moves the current position: reload on a send, reload plus one on a first read, plus one on a following read, and no movement on quick commands, writes and strobes for another address. They also check that the read response lines up with its strobe. Only the bench scenarios can show what is stored: write contents and their wrap past 255, data read back across the top of the array, the zeroed array after reset, and that writes aimed at another address leave the array untouched.

// File: rtl/smb_ee_pkg.sv
package smb_ee_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_QUICK  = 3'd1,
    OP_SEND   = 3'd2,
    OP_RNEXT  = 3'd3,
    OP_RFIRST = 3'd4,
    OP_WCMD   = 3'd5,
    OP_WDAT   = 3'd6
  } ee_op_e;

  function automatic logic [7:0] step8(input logic [7:0] a);
    return a + 8'd1;
  endfunction

endpackage

// File: rtl/smb_ee_decode.sv
module smb_ee_decode #(
  parameter logic [6:0] BUS_ADDR = 7'h50
) (
  input  logic [6:0]           sel_addr_i,
  input  logic                 quick_i,
  input  logic                 send_i,
  input  logic                 recv_i,
  input  logic                 wcmd_i,
  input  logic                 wdat_i,
  input  logic                 rdat_i,
  input  logic                 rdat_first_i,
  output logic                 sel_hit,
  output smb_ee_pkg::ee_op_e   op
);
  import smb_ee_pkg::*;

  assign sel_hit = (sel_addr_i == BUS_ADDR);

  // precedence: writes, then send, then reads, then quick
  always_comb begin
    op = OP_NONE;
    if (sel_hit) begin
      if (wcmd_i)      op = OP_WCMD;
      else if (wdat_i) op = OP_WDAT;
      else if (send_i) op = OP_SEND;
      else if (rdat_i) op = rdat_first_i ? OP_RFIRST : OP_RNEXT;
      else if (recv_i) op = OP_RNEXT;
      else if (quick_i) op = OP_QUICK;
    end
  end
endmodule

// File: rtl/smb_ee_ptr.sv
module smb_ee_ptr #(
  parameter int AW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  smb_ee_pkg::ee_op_e op,
  input  logic [7:0]         byte_i,
  output logic [AW-1:0]      pos_q,
  output logic               rd_en,
  output logic [AW-1:0]      rd_addr,
  output logic               wr_en,
  output logic [AW-1:0]      wr_addr
);
  import smb_ee_pkg::*;

  logic [AW-1:0] wptr_q;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  always_comb begin
    rd_en   = (op == OP_RFIRST) || (op == OP_RNEXT);
    rd_addr = (op == OP_RFIRST) ? byte_i[AW-1:0] : pos_q;
    wr_en   = (op == OP_WDAT);
    wr_addr = wptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      wptr_q <= '0;
    end else begin
      case (op)
        OP_SEND:            pos_q  <= byte_i[AW-1:0];
        OP_RFIRST,
        OP_RNEXT:           pos_q  <= wrap_inc(rd_addr);
        OP_WCMD:            wptr_q <= byte_i[AW-1:0];
        OP_WDAT:            wptr_q <= wrap_inc(wptr_q);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/smb_ee_store.sv
module smb_ee_store #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata_q,
  output logic          rvalid_q
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= 8'h00;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= re;
      if (re) rdata_q <= mem[raddr];
    end
  end
endmodule

// File: rtl/smb_eeprom.sv
module smb_eeprom #(
  parameter logic [6:0] BUS_ADDR = 7'h50,
  parameter int         AW       = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] sel_addr_i,
  input  logic       quick_i,
  input  logic       send_i,
  input  logic       recv_i,
  input  logic       wcmd_i,
  input  logic       wdat_i,
  input  logic       rdat_i,
  input  logic       rdat_first_i,
  input  logic [7:0] byte_i,
  output logic [7:0] rd_data_o,
  output logic       rd_valid_o
);
  import smb_ee_pkg::*;

  ee_op_e        op;
  logic          sel_hit;
  logic [AW-1:0] pos_q;
  logic          rd_en, wr_en;
  logic [AW-1:0] rd_addr, wr_addr;

  smb_ee_decode #(.BUS_ADDR(BUS_ADDR)) u_dec (
    .sel_addr_i(sel_addr_i), .quick_i(quick_i), .send_i(send_i),
    .recv_i(recv_i), .wcmd_i(wcmd_i), .wdat_i(wdat_i), .rdat_i(rdat_i),
    .rdat_first_i(rdat_first_i), .sel_hit(sel_hit), .op(op)
  );

  smb_ee_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .op(op), .byte_i(byte_i), .pos_q(pos_q),
    .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr)
  );

  smb_ee_store #(.AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_addr), .wdata(byte_i),
    .re(rd_en), .raddr(rd_addr), .rdata_q(rd_data_o), .rvalid_q(rd_valid_o)
  );
endmodule

// File: rtl/smb_eeprom_chk.sv
module smb_eeprom_chk #(
  parameter int AW = 8
) (
  input logic               clk,
  input logic               rst_n,
  input smb_ee_pkg::ee_op_e op,
  input logic               sel_hit,
  input logic [7:0]         byte_i,
  input logic [AW-1:0]      pos_q,
  input logic               rd_valid_o
);
  import smb_ee_pkg::*;

  // R2
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_hit |=> ($stable(pos_q) && !rd_valid_o));

  // R5
  first_read_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RFIRST) |=> (pos_q == AW'($past(byte_i[AW-1:0]) + AW'(1))));

  // R6
  next_read_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RNEXT) |=> (pos_q == AW'($past(pos_q) + AW'(1))));

  // R7
  send_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SEND) |=> (pos_q == $past(byte_i[AW-1:0])));

  // R8
  quick_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_QUICK) |=> $stable(pos_q));

  // R9
  write_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_WCMD) || (op == OP_WDAT)) |=> $stable(pos_q));

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_RFIRST) || (op == OP_RNEXT)) |=> rd_valid_o);

  // R10
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((op == OP_RFIRST) || (op == OP_RNEXT)) |=> !rd_valid_o);
endmodule

bind smb_eeprom smb_eeprom_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .sel_hit(sel_hit), .byte_i(byte_i),
  .pos_q(pos_q), .rd_valid_o(rd_valid_o)
);

// File: tb/tb_smb_eeprom.sv
module tb_smb_eeprom;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] sel_addr_i = 7'h50;
  logic       quick_i = 0, send_i = 0, recv_i = 0, wcmd_i = 0, wdat_i = 0;
  logic       rdat_i = 0, rdat_first_i = 0;
  logic [7:0] byte_i = 8'h00;
  logic [7:0] rd_data_o;
  logic       rd_valid_o;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] model [256];
  logic [7:0] mpos = 8'h00;
  logic [7:0] mwptr = 8'h00;

  always #5 clk = ~clk;

  smb_eeprom #(.BUS_ADDR(7'h50)) dut (
    .clk(clk), .rst_n(rst_n), .sel_addr_i(sel_addr_i), .quick_i(quick_i),
    .send_i(send_i), .recv_i(recv_i), .wcmd_i(wcmd_i), .wdat_i(wdat_i),
    .rdat_i(rdat_i), .rdat_first_i(rdat_first_i), .byte_i(byte_i),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic clear_strobes();
    quick_i = 0; send_i = 0; recv_i = 0; wcmd_i = 0; wdat_i = 0;
    rdat_i = 0; rdat_first_i = 0;
  endtask

  // kind: 0 quick, 1 send, 2 wcmd, 3 wdat
  task automatic strobe(input int kind, input logic [7:0] b, input string req);
    @(negedge clk);
    byte_i = b;
    case (kind)
      0: quick_i = 1;
      1: send_i = 1;
      2: wcmd_i = 1;
      default: wdat_i = 1;
    endcase
    @(negedge clk);
    clear_strobes();
    chk(req, "no read response", {7'd0, rd_valid_o}, 8'h00);
    if (sel_addr_i == 7'h50) begin
      if (kind == 1) mpos = b;
      if (kind == 2) mwptr = b;
      if (kind == 3) begin model[mwptr] = b; mwptr = mwptr + 8'd1; end
    end
  endtask

  // kind: 0 receive-byte, 1 read-data next, 2 read-data first
  task automatic rd(input int kind, input logic [7:0] b, input string req);
    logic [7:0] a;
    @(negedge clk);
    byte_i = b;
    if (kind == 0) recv_i = 1;
    else begin rdat_i = 1; rdat_first_i = (kind == 2); end
    @(negedge clk);
    clear_strobes();
    a = (kind == 2) ? b : mpos;
    chk(req, "valid", {7'd0, rd_valid_o}, 8'h01);
    chk(req, "data", rd_data_o, model[a]);
    mpos = a + 8'd1;
  endtask

  task automatic t_reset();
    chk("R1", "valid after reset", {7'd0, rd_valid_o}, 8'h00);
    rd(0, 8'h00, "R1");
    rd(2, 8'hFF, "R1");
    rd(0, 8'h00, "R1 pos wrap R6");
  endtask

  task automatic t_write_read();
    strobe(2, 8'h10, "R3");
    strobe(3, 8'hAA, "R3");
    strobe(3, 8'hBB, "R3");
    strobe(3, 8'hCC, "R3");
    rd(2, 8'h10, "R3 R5");
    rd(1, 8'h00, "R6");
    rd(1, 8'h00, "R6");
    rd(0, 8'h00, "R6 recv");
  endtask

  task automatic t_wrap();
    strobe(2, 8'hFE, "R4");
    strobe(3, 8'h11, "R4");
    strobe(3, 8'h22, "R4");
    strobe(3, 8'h33, "R4");
    strobe(3, 8'h44, "R4");
    rd(2, 8'hFE, "R4");
    rd(1, 8'h00, "R4");
    rd(1, 8'h00, "R4 R6 wrap");
    rd(1, 8'h00, "R4");
  endtask

  task automatic t_send_quick();
    strobe(1, 8'h11, "R7");
    rd(0, 8'h00, "R7");
    strobe(1, 8'h10, "R8");
    strobe(0, 8'h77, "R8");
    rd(0, 8'h00, "R8");
  endtask

  task automatic t_write_keeps_pos();
    strobe(1, 8'h12, "R9");
    strobe(2, 8'h40, "R9");
    strobe(3, 8'h55, "R9");
    rd(0, 8'h00, "R9");
    rd(2, 8'h40, "R9 stored");
  endtask

  task automatic t_other_addr();
    sel_addr_i = 7'h51;
    strobe(2, 8'h10, "R2");
    strobe(3, 8'h99, "R2");
    strobe(1, 8'h80, "R2");
    @(negedge clk); recv_i = 1;
    @(negedge clk); clear_strobes();
    chk("R2", "no response for other address", {7'd0, rd_valid_o}, 8'h00);
    sel_addr_i = 7'h50;
    rd(0, 8'h00, "R2 position kept");
    rd(2, 8'h10, "R2 array kept");
  endtask

  task automatic t_valid_pulse();
    rd(0, 8'h00, "R10");
    @(negedge clk);
    chk("R10", "single pulse", {7'd0, rd_valid_o}, 8'h00);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_wrap();
    t_send_quick();
    t_write_keeps_pos();
    t_other_addr();
    t_valid_pulse();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule